// File: doc/BRIEF.md
# Byte-Window Frame Network Interface

This block is a bus-slave peripheral that carries one network frame at a time in each direction between a processor and a byte-stream link. Software works through a small register window addressed by six address bits. It pulls a received frame out one byte per read of a receive data window, and it pushes an outgoing frame in one byte per write to a transmit data window. The block keeps a single receive buffer and a single transmit buffer, each up to 1514 bytes. It raises one level interrupt while any event bit is pending.

Received bytes arrive as a stream with valid and last flags and no back-pressure. The block decides whether to take a frame on its first beat. A frame it cannot take is discarded whole, and bytes past 1514 are dropped. The transmit side presents the stored frame as a valid/ready stream. `tx_valid`, `tx_data` and `tx_last` hold steady until the sink raises `tx_ready`, and the sink may stall for any number of cycles. A busy flag reflects pending events and blocks reception while it is set. An event-control register clears events in priority order. One of its write values performs a soft reset and leaves a self-clearing test event behind.

Top module: `frame_nic`

## Requirements
- R1: After reset, busy reads 1, both byte counts and the event register read 0, `irq` is low and `tx_valid` is low.
- R2: Register offsets (bits [5:0] of the address) are 0x00 tag "FNIC", 0x04 tag "FBUF", 0x08 busy, 0x0C RX count, 0x10 TX count, 0x14 event control, 0x18 event info, 0x1C RX window and 0x20 TX window. The tags are ASCII with the first character in bits [31:24]. Event info, the TX window and every other offset read 0.
- R3: Writes to offsets 0x00, 0x04, 0x08, 0x0C, 0x18 and 0x1C change nothing.
- R4: In the event register, bit 0 is TX done, bit 1 is RX done and bit 31 is test. `irq` is high exactly when any of these bits is set.
- R5: An event write with bit 0 set clears only TX done. Otherwise, if bit 1 is set, it clears only RX done. Otherwise, if bit 31 is set, it performs a soft reset. A write of 0 changes no bit.
- R6: After any event write, busy equals 1 if any event bit is still set and 0 otherwise. A read of the event register returns its value and clears the test bit, and the read does not change busy.
- R7: A soft reset zeroes the RX count, RX read position, TX count, TX write position and the other event bits. It sets busy and leaves only the test bit set, and it aborts any receive in progress.
- R8: A frame is taken only if, on its first beat, busy is 0 and the RX count is below 1514. Taking a frame sets busy at once and zeroes the RX count until the frame ends. A frame that is not taken leaves the RX count and the event bits unchanged.
- R9: At the last beat of a taken frame, the RX count becomes its length, capped at 1514 (the first 1514 bytes are kept), the read position returns to 0 and RX done is set.
- R10: A read of the RX window while the RX count is nonzero returns the next byte in bits [7:0], advances the position and decrements the count. At count 0 it returns 0 and changes nothing.
- R11: A TX count write loads the written value if it is at most 1514 and loads 0 otherwise. In both cases the TX write position returns to 0.
- R12: A TX window write stores bits [7:0] and advances the position. When the position reaches the TX count, the frame is sent in write order with `tx_last` on its final byte, the TX count clears, TX done is set and busy is set.
- R13: While a frame is still streaming out, TX window writes are ignored. A stalled beat keeps `tx_valid`, `tx_data` and `tx_last` unchanged.
- R14: If a frame's last beat falls in the same cycle as an event write that clears RX done, RX done ends up set and busy ends up 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset into the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address (combinational) |
| rx_valid | input | 1 | Receive byte present |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final byte of a receive frame |
| tx_valid | output | 1 | Transmit byte present |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the transmit frame |
| tx_ready | input | 1 | Sink accepts the transmit byte |
| irq | output | 1 | Level interrupt, high while any event bit is set |

## Verification
The set-versus-clear collision on RX done is the case that needs care. A receive frame's last beat can land in the same cycle as a software write that clears RX done. The bench starts the frame stream and the event write together, so the final beat and the write meet the same rising edge. It then judges the outcome from the register window: RX done must still be set, `irq` must be high, busy must read 1 and the RX count must equal the frame length. A TX window write arriving while a frame is still draining under a stalled sink is checked the same way. The bench confirms that no TX done is raised and that no extra frame appears on the stream.

// File: rtl/fnic_pkg.sv
package fnic_pkg;
  // Register offsets within the six-bit window
  localparam logic [5:0] OFS_TAG_HI   = 6'h00;
  localparam logic [5:0] OFS_TAG_LO   = 6'h04;
  localparam logic [5:0] OFS_BUSY     = 6'h08;
  localparam logic [5:0] OFS_RX_LEN   = 6'h0C;
  localparam logic [5:0] OFS_TX_LEN   = 6'h10;
  localparam logic [5:0] OFS_EVT      = 6'h14;
  localparam logic [5:0] OFS_EVT_INFO = 6'h18;
  localparam logic [5:0] OFS_RX_WIN   = 6'h1C;
  localparam logic [5:0] OFS_TX_WIN   = 6'h20;

  // Event register bit positions
  localparam int EVB_TX   = 0;
  localparam int EVB_RX   = 1;
  localparam int EVB_TEST = 31;

  // Identification words, first character in the top byte
  localparam logic [31:0] TAG_HI = 32'h464E_4943; // "FNIC"
  localparam logic [31:0] TAG_LO = 32'h4642_5546; // "FBUF"

  typedef struct packed {
    logic test;
    logic rx_done;
    logic tx_done;
  } evt_bits_t;
endpackage

// File: rtl/fnic_evt.sv
module fnic_evt
  import fnic_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_i,
  input  evt_bits_t   wbits_i,
  input  logic        rd_i,
  input  logic        set_tx_i,
  input  logic        set_rx_i,
  input  logic        hold_i,
  output logic        soft_rst_o,
  output logic        busy_o,
  output logic        irq_o,
  output logic [31:0] ctl_o
);
  evt_bits_t ev_q, ev_nxt;
  logic      busy_q, busy_nxt;

  assign soft_rst_o = wr_i && !wbits_i.tx_done && !wbits_i.rx_done && wbits_i.test;

  always_comb begin
    ev_nxt = ev_q;
    if (rd_i) ev_nxt.test = 1'b0;
    if (wr_i) begin
      if (wbits_i.tx_done)      ev_nxt.tx_done = 1'b0;
      else if (wbits_i.rx_done) ev_nxt.rx_done = 1'b0;
      else if (wbits_i.test)    ev_nxt = '{test: 1'b1, rx_done: 1'b0, tx_done: 1'b0};
    end
    ev_nxt.tx_done = ev_nxt.tx_done | set_tx_i;
    ev_nxt.rx_done = ev_nxt.rx_done | set_rx_i;
    busy_nxt = busy_q;
    if (wr_i) busy_nxt = |ev_nxt;
    if (set_tx_i || set_rx_i || hold_i) busy_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q   <= '0;
      busy_q <= 1'b1;
    end else begin
      ev_q   <= ev_nxt;
      busy_q <= busy_nxt;
    end
  end

  always_comb begin
    ctl_o           = '0;
    ctl_o[EVB_TX]   = ev_q.tx_done;
    ctl_o[EVB_RX]   = ev_q.rx_done;
    ctl_o[EVB_TEST] = ev_q.test;
  end

  assign busy_o = busy_q;
  assign irq_o  = |ev_q;

  // R6
  test_rdclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i && !wr_i |=> !ctl_o[EVB_TEST]);

  // R5
  tx_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i && wbits_i.tx_done && !set_tx_i |=>
      !ctl_o[EVB_TX] && (!$past(ctl_o[EVB_RX]) || ctl_o[EVB_RX]));
endmodule

// File: rtl/fnic_rx.sv
module fnic_rx #(
  parameter int FRAME_MAX = 1514,
  localparam int CNT_W = $clog2(FRAME_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst_i,
  input  logic             busy_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_data_i,
  input  logic             rx_last_i,
  input  logic             pop_i,
  output logic [CNT_W-1:0] count_o,
  output logic [7:0]       byte_o,
  output logic             accept_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(FRAME_MAX);

  logic [7:0]       mem [FRAME_MAX];
  logic [CNT_W-1:0] count_q, rdptr_q, wridx_q;
  logic             in_frame_q, keep_q;
  logic             first, take, room;
  logic [CNT_W-1:0] idx, len;

  assign first    = rx_valid_i && !in_frame_q;
  assign accept_o = first && !busy_i && (count_q < LIMIT) && !soft_rst_i;
  assign idx      = in_frame_q ? wridx_q : '0;
  assign take     = rx_valid_i && !soft_rst_i && (first ? accept_o : keep_q);
  assign room     = idx < LIMIT;
  assign len      = room ? idx + CNT_W'(1) : idx;
  assign done_o   = take && rx_last_i;

  always_ff @(posedge clk) begin
    if (take && room) mem[idx] <= rx_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      keep_q     <= 1'b0;
      wridx_q    <= '0;
      count_q    <= '0;
      rdptr_q    <= '0;
    end else begin
      if (rx_valid_i) begin
        in_frame_q <= !rx_last_i;
        if (first) keep_q <= accept_o;
        if (take) wridx_q <= len;
      end
      if (soft_rst_i) keep_q <= 1'b0;

      if (soft_rst_i) begin
        count_q <= '0;
        rdptr_q <= '0;
      end else if (done_o) begin
        count_q <= len;
        rdptr_q <= '0;
      end else if (accept_o) begin
        count_q <= '0;
        rdptr_q <= '0;
      end else if (pop_i && count_q != '0) begin
        count_q <= count_q - CNT_W'(1);
        rdptr_q <= rdptr_q + CNT_W'(1);
      end
    end
  end

  assign count_o = count_q;
  assign byte_o  = (count_q != '0 && rdptr_q < LIMIT) ? mem[rdptr_q] : 8'h00;

  // R9
  rx_len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= LIMIT);

  // R10
  rx_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i && count_q != '0 && !accept_o && !done_o && !soft_rst_i |=>
      count_q == $past(count_q) - CNT_W'(1));
endmodule

// File: rtl/fnic_tx.sv
module fnic_tx #(
  parameter int FRAME_MAX = 1514,
  localparam int CNT_W = $clog2(FRAME_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst_i,
  input  logic             cnt_we_i,
  input  logic [31:0]      cnt_wdata_i,
  input  logic             data_we_i,
  input  logic [7:0]       data_wdata_i,
  input  logic             tx_ready_i,
  output logic [CNT_W-1:0] count_o,
  output logic             tx_valid_o,
  output logic [7:0]       tx_data_o,
  output logic             tx_last_o,
  output logic             launch_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(FRAME_MAX);

  logic [7:0]       mem [FRAME_MAX];
  logic [CNT_W-1:0] cnt_q, wptr_q, dlen_q, dptr_q;
  logic             drain_q, wr_ok;

  assign wr_ok    = data_we_i && !drain_q && (wptr_q < LIMIT);
  assign launch_o = wr_ok && (wptr_q + CNT_W'(1) == cnt_q);

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr_q] <= data_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      wptr_q  <= '0;
      drain_q <= 1'b0;
      dlen_q  <= '0;
      dptr_q  <= '0;
    end else begin
      if (soft_rst_i) begin
        cnt_q  <= '0;
        wptr_q <= '0;
      end else if (cnt_we_i) begin
        cnt_q  <= (cnt_wdata_i <= 32'(FRAME_MAX)) ? cnt_wdata_i[CNT_W-1:0] : '0;
        wptr_q <= '0;
      end else if (launch_o) begin
        cnt_q  <= '0;
        wptr_q <= '0;
      end else if (wr_ok) begin
        wptr_q <= wptr_q + CNT_W'(1);
      end

      if (launch_o) begin
        drain_q <= 1'b1;
        dlen_q  <= cnt_q;
        dptr_q  <= '0;
      end else if (drain_q && tx_ready_i) begin
        if (tx_last_o) drain_q <= 1'b0;
        else           dptr_q  <= dptr_q + CNT_W'(1);
      end
    end
  end

  assign count_o    = cnt_q;
  assign tx_valid_o = drain_q;
  assign tx_data_o  = (dptr_q < LIMIT) ? mem[dptr_q] : 8'h00;
  assign tx_last_o  = drain_q && (dptr_q == dlen_q - CNT_W'(1));

  // R13
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o));

  // R11
  tx_len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);

  // R12
  tx_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch_o |=> tx_valid_o && cnt_q == '0);
endmodule

// File: rtl/frame_nic.sv
module frame_nic
  import fnic_pkg::*;
#(
  parameter int FRAME_MAX = 1514,
  localparam int CNT_W = $clog2(FRAME_MAX + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_wr,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        tx_ready,
  output logic        irq
);
  logic             rd_cyc, wr_cyc;
  logic             soft_rst, busy;
  logic             rx_accept, rx_done, tx_launch;
  logic [CNT_W-1:0] rx_count, tx_count;
  logic [7:0]       rx_byte;
  logic [31:0]      evt_word;
  evt_bits_t        evt_wbits;

  assign rd_cyc    = bus_en && !bus_wr;
  assign wr_cyc    = bus_en && bus_wr;
  assign evt_wbits = '{test: bus_wdata[EVB_TEST], rx_done: bus_wdata[EVB_RX],
                       tx_done: bus_wdata[EVB_TX]};

  fnic_evt u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (wr_cyc && bus_addr == OFS_EVT),
    .wbits_i    (evt_wbits),
    .rd_i       (rd_cyc && bus_addr == OFS_EVT),
    .set_tx_i   (tx_launch),
    .set_rx_i   (rx_done),
    .hold_i     (rx_accept),
    .soft_rst_o (soft_rst),
    .busy_o     (busy),
    .irq_o      (irq),
    .ctl_o      (evt_word)
  );

  fnic_rx #(.FRAME_MAX(FRAME_MAX)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst_i (soft_rst),
    .busy_i     (busy),
    .rx_valid_i (rx_valid),
    .rx_data_i  (rx_data),
    .rx_last_i  (rx_last),
    .pop_i      (rd_cyc && bus_addr == OFS_RX_WIN),
    .count_o    (rx_count),
    .byte_o     (rx_byte),
    .accept_o   (rx_accept),
    .done_o     (rx_done)
  );

  fnic_tx #(.FRAME_MAX(FRAME_MAX)) u_tx (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst_i   (soft_rst),
    .cnt_we_i     (wr_cyc && bus_addr == OFS_TX_LEN),
    .cnt_wdata_i  (bus_wdata),
    .data_we_i    (wr_cyc && bus_addr == OFS_TX_WIN),
    .data_wdata_i (bus_wdata[7:0]),
    .tx_ready_i   (tx_ready),
    .count_o      (tx_count),
    .tx_valid_o   (tx_valid),
    .tx_data_o    (tx_data),
    .tx_last_o    (tx_last),
    .launch_o     (tx_launch)
  );

  always_comb begin
    unique case (bus_addr)
      OFS_TAG_HI: bus_rdata = TAG_HI;
      OFS_TAG_LO: bus_rdata = TAG_LO;
      OFS_BUSY:   bus_rdata = {31'b0, busy};
      OFS_RX_LEN: bus_rdata = {{(32-CNT_W){1'b0}}, rx_count};
      OFS_TX_LEN: bus_rdata = {{(32-CNT_W){1'b0}}, tx_count};
      OFS_EVT:    bus_rdata = evt_word;
      OFS_RX_WIN: bus_rdata = {24'b0, rx_byte};
      default:    bus_rdata = '0;
    endcase
  end

  // R7
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> busy && irq && rx_count == '0 && tx_count == '0);
endmodule

// File: tb/sim_frame_nic.sv
module sim_frame_nic;
  import fnic_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n, bus_en, bus_wr, rx_valid, rx_last, tx_ready;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  rx_data, tx_data;
  logic        tx_valid, tx_last, irq;

  always #2 clk = ~clk;

  frame_nic u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_ready(tx_ready), .irq(irq)
  );

  int         n_chk = 0;
  int         n_fail = 0;
  logic [8:0] exp_q[$];
  bit         bp = 0;
  bit         stall = 0;
  bit         finished = 0;
  logic [7:0] lfsr = 8'h5A;

  function automatic logic [7:0] pat(logic [7:0] seed, int i);
    return seed + 8'(i * 7);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_chk(logic [5:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    chk(bus_rdata === exp, req, bus_rdata, exp);
    @(posedge clk);
    #1 bus_en = 1'b0;
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rx_frame(int len, logic [7:0] seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = pat(seed, i); rx_last = (i == len - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  // Driver: records the expected beat, then writes the byte
  task automatic tx_send(logic [7:0] b, bit last);
    exp_q.push_back({last, b});
    wr(OFS_TX_WIN, 32'hAB00 | {24'b0, b});
  endtask

  task automatic drain_wait();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // Sink ready pattern
  initial begin
    tx_ready = 1'b0;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      tx_ready = stall ? 1'b0 : (bp ? lfsr[0] : 1'b1);
    end
  end

  // Monitor: compares every accepted beat against the queue (R12)
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n === 1'b1 && tx_valid && tx_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R12 unexpected beat", {23'b0, tx_last, tx_data}, 32'h0);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk({tx_last, tx_data} == e, "R12 stream beat", {23'b0, tx_last, tx_data}, {23'b0, e});
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_en = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rx_valid = 1'b0; rx_data = '0; rx_last = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1
    chk(irq == 1'b0, "R1 irq", {31'b0, irq}, 0);
    chk(tx_valid == 1'b0, "R1 tx_valid", {31'b0, tx_valid}, 0);
    rd_chk(OFS_BUSY, 1, "R1 busy");
    rd_chk(OFS_RX_LEN, 0, "R1 rx count");
    rd_chk(OFS_TX_LEN, 0, "R1 tx count");
    rd_chk(OFS_EVT, 0, "R1 events");

    // R2
    rd_chk(OFS_TAG_HI, 32'h464E4943, "R2 tag hi");
    rd_chk(OFS_TAG_LO, 32'h46425546, "R2 tag lo");
    rd_chk(OFS_EVT_INFO, 0, "R2 info");
    rd_chk(OFS_TX_WIN, 0, "R2 tx window");
    rd_chk(6'h24, 0, "R2 unmapped 0x24");
    rd_chk(6'h3C, 0, "R2 unmapped 0x3C");
    rd_chk(6'h01, 0, "R2 unaligned");

    // R8: busy after reset drops the frame
    rx_frame(5, 8'h11);
    rd_chk(OFS_RX_LEN, 0, "R8 dropped while busy");
    rd_chk(OFS_EVT, 0, "R8 no event on drop");

    // R6: zero write recomputes busy
    wr(OFS_EVT, 0);
    rd_chk(OFS_BUSY, 0, "R6 busy after ack");

    // R9 / R10 / R4
    rx_frame(6, 8'h10);
    #1 chk(irq == 1'b1, "R4 irq on rx done", {31'b0, irq}, 1);
    rd_chk(OFS_EVT, 32'h2, "R4 rx done bit");
    rd_chk(OFS_BUSY, 1, "R8 busy on accept");
    rd_chk(OFS_RX_LEN, 6, "R9 rx length");
    for (int i = 0; i < 6; i++) rd_chk(OFS_RX_WIN, {24'b0, pat(8'h10, i)}, "R10 rx byte");
    rd_chk(OFS_RX_WIN, 0, "R10 empty read");
    rd_chk(OFS_RX_LEN, 0, "R10 count stays 0");

    // R3: writes to read-only offsets
    wr(OFS_TAG_HI, 32'hFFFF_FFFF);
    wr(OFS_BUSY, 0);
    wr(OFS_RX_LEN, 5);
    wr(OFS_EVT_INFO, 32'h1234);
    wr(OFS_RX_WIN, 32'h99);
    rd_chk(OFS_TAG_HI, 32'h464E4943, "R3 tag unchanged");
    rd_chk(OFS_BUSY, 1, "R3 busy unchanged");
    rd_chk(OFS_RX_LEN, 0, "R3 rx count unchanged");
    rd_chk(OFS_EVT, 32'h2, "R3 events unchanged");

    // R8: pending RX done keeps busy, frame dropped
    rx_frame(3, 8'h70);
    rd_chk(OFS_RX_LEN, 0, "R8 dropped while event pending");

    // R5 priority
    wr(OFS_EVT, 32'h8000_0003);
    rd_chk(OFS_EVT, 32'h2, "R5 bit0 wins, rx kept, no test");
    rd_chk(OFS_BUSY, 1, "R6 busy follows pending");
    wr(OFS_EVT, 32'h8000_0002);
    rd_chk(OFS_EVT, 0, "R5 rx cleared");
    #1 chk(irq == 1'b0, "R4 irq low", {31'b0, irq}, 0);
    rd_chk(OFS_BUSY, 0, "R6 busy clear");

    // R14: completion and RX clear in one cycle
    fork
      rx_frame(4, 8'h40);
      begin
        repeat (3) @(negedge clk);
        wr(OFS_EVT, 32'h2);
      end
    join
    rd_chk(OFS_EVT, 32'h2, "R14 rx done survives clear");
    #1 chk(irq == 1'b1, "R14 irq", {31'b0, irq}, 1);
    rd_chk(OFS_BUSY, 1, "R14 busy");
    rd_chk(OFS_RX_LEN, 4, "R14 length");
    rd_chk(OFS_RX_WIN, {24'b0, pat(8'h40, 0)}, "R14 first byte");

    // R7 soft reset
    wr(OFS_TX_LEN, 10);
    wr(OFS_TX_WIN, 32'h1);
    wr(OFS_TX_WIN, 32'h2);
    wr(OFS_EVT, 32'h8000_0000);
    #1 chk(irq == 1'b1, "R7 irq on test", {31'b0, irq}, 1);
    rd_chk(OFS_BUSY, 1, "R7 busy");
    rd_chk(OFS_TX_LEN, 0, "R7 tx count");
    rd_chk(OFS_RX_LEN, 0, "R7 rx count");
    rd_chk(OFS_EVT, 32'h8000_0000, "R7 only test set");
    #1 chk(irq == 1'b0, "R6 test cleared by read", {31'b0, irq}, 0);
    rd_chk(OFS_BUSY, 1, "R6 read leaves busy");
    rd_chk(OFS_EVT, 0, "R6 events after read");
    wr(OFS_EVT, 0);
    rd_chk(OFS_BUSY, 0, "R6 ack clears busy");

    // R11
    wr(OFS_TX_LEN, 1515);
    rd_chk(OFS_TX_LEN, 0, "R11 over limit");
    wr(OFS_TX_LEN, 1514);
    rd_chk(OFS_TX_LEN, 1514, "R11 at limit");
    wr(OFS_TX_LEN, 32'hFFFF_FFFF);
    rd_chk(OFS_TX_LEN, 0, "R11 huge value");

    // R12 with random back-pressure
    bp = 1;
    wr(OFS_TX_LEN, 5);
    for (int i = 0; i < 5; i++) tx_send(8'h30 + 8'(i), i == 4);
    rd_chk(OFS_EVT, 32'h1, "R12 tx done");
    rd_chk(OFS_BUSY, 1, "R12 busy on send");
    rd_chk(OFS_TX_LEN, 0, "R12 count cleared");
    drain_wait();

    // R13: writes ignored while draining
    stall = 1;
    wr(OFS_TX_LEN, 3);
    tx_send(8'hA1, 0);
    tx_send(8'hA2, 0);
    tx_send(8'hA3, 1);
    wr(OFS_EVT, 32'h1);
    wr(OFS_TX_LEN, 1);
    wr(OFS_TX_WIN, 32'h77);
    rd_chk(OFS_EVT, 0, "R13 no launch while draining");
    rd_chk(OFS_BUSY, 0, "R13 busy unchanged");
    #1 chk(tx_valid == 1'b1 && tx_data == 8'hA1, "R13 stalled beat held",
           {23'b0, tx_valid, tx_data}, {23'b0, 1'b1, 8'hA1});
    stall = 0; bp = 0;
    drain_wait();
    #1 chk(tx_valid == 1'b0, "R13 no extra frame", {31'b0, tx_valid}, 0);
    tx_send(8'h55, 1);
    drain_wait();
    rd_chk(OFS_EVT, 32'h1, "R12 single-byte frame");

    // R9 truncation, R8 full buffer
    wr(OFS_EVT, 32'h1);
    rx_frame(1520, 8'h21);
    rd_chk(OFS_RX_LEN, 1514, "R9 truncated length");
    rd_chk(OFS_EVT, 32'h2, "R9 rx done");
    wr(OFS_EVT, 32'h2);
    rd_chk(OFS_BUSY, 0, "R6 busy after clear");
    rx_frame(2, 8'h05);
    rd_chk(OFS_RX_LEN, 1514, "R8 full buffer drops");
    rd_chk(OFS_EVT, 0, "R8 no event when full");
    rd_chk(OFS_RX_WIN, {24'b0, pat(8'h21, 0)}, "R9 kept first byte");
    rd_chk(OFS_RX_LEN, 1513, "R10 count decrements");

    chk(exp_q.size() == 0, "R12 all beats seen", exp_q.size(), 0);
    finished = 1;
    summary();
    $finish;
  end
endmodule